// File: doc/BRIEF.md
# Dual-Packet Lane Byte Deinterleaver

This block sits behind the symbol decoder of one serial lane. Each clock it takes one aligned, already-decoded byte. The lane carries two logical units at once, one for each of two packets. Their bytes alternate: the even slots belong to packet 0 and the odd slots belong to packet 1. The block splits this stream into a high channel, which carries packet 0, and a low channel, which carries packet 1. Each channel runs at half the input byte rate.

A start pulse on the input marks byte 0 of packet 0. From that point the block counts the byte position inside the unit, using a length of 8, 9 or 10 bytes. The length is chosen per unit by a two-bit mode input. Once a unit pair ends, the next pair begins on the very next input byte, with no idle gap between them. Each output pair carries its byte index and flags for the first and last bytes, so that the next stage can tell header bytes from payload bytes.

Top module: `lane_pair_splitter`

## Requirements
- R1: After reset, `out_valid` stays low until the first `in_sof` is accepted. Bytes that arrive before it are ignored.
- R2: A byte taken with `in_sof`, or taken in an even slot, is presented on `out_hi`. The byte in the next slot (the odd slot) is presented on `out_lo`. Both bytes appear together on the clock edge that accepts the odd byte.
- R3: `out_valid` is high for exactly one clock per byte pair. It is never high on two consecutive clocks while the stream runs.
- R4: `out_idx` counts 0, 1, …, L-1 over successive pairs and then wraps to 0. The byte after the last odd byte is taken as byte 0 of packet 0 of the next unit, with no gap.
- R5: The unit length L comes from `len_mode`: 0 gives 8, 1 gives 9, 2 gives 10 and 3 gives 8.
- R6: `out_first` is high exactly on the pair with index 0. `out_last` is high exactly on the pair with index L-1.
- R7: `len_mode` is sampled only on the clock that takes byte 0 of packet 0. If it changes at any other time, the unit in progress keeps its length.
- R8: `in_sof` restarts framing on any clock: the byte it comes with becomes byte 0 of packet 0. If half a pair is pending, that half is discarded, and `out_valid` stays low on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sof | input | 1 | Marks packet 0 byte 0 of a unit pair |
| in_byte | input | W | Decoded lane byte |
| len_mode | input | 2 | Unit length select (0:8, 1:9, 2:10, 3:8) |
| out_valid | output | 1 | Output pair strobe |
| out_hi | output | W | Packet 0 byte (high channel) |
| out_lo | output | W | Packet 1 byte (low channel) |
| out_idx | output | IW | Byte index inside the unit |
| out_first | output | 1 | Pair has index 0 |
| out_last | output | 1 | Pair has index L-1 |

## Verification
Two functions can fall on the same clock. The first pair is a restart pulse and the odd-slot completion of a pair: the bench abandons a unit after an odd number of bytes, at both a short and a nearly full length, and raises `in_sof` in the slot that would have completed the pair. It then checks that no strobe appears and that the next pair carries index 0 with the new bytes. The second pair is the unit wrap and a change in length: the bench walks through every length mode back to back and toggles `len_mode` on every byte except byte 0. It judges each `out_last` against the length that was selected at that unit's start.

// File: rtl/lane_pair_splitter.sv
module lane_pair_splitter #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sof,
  input  logic [W-1:0]  in_byte,
  input  logic [1:0]    len_mode,
  output logic          out_valid,
  output logic [W-1:0]  out_hi,
  output logic [W-1:0]  out_lo,
  output logic [IW-1:0] out_idx,
  output logic          out_first,
  output logic          out_last
);

  logic          active;
  logic          odd;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic [W-1:0]  hold;
  logic [IW-1:0] len_last;

  assign len_last = (len_mode == 2'd1) ? IW'(8) :
                    (len_mode == 2'd2) ? IW'(9) : IW'(7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      odd       <= 1'b0;
      idx       <= '0;
      last_idx  <= IW'(7);
      hold      <= '0;
      out_valid <= 1'b0;
      out_hi    <= '0;
      out_lo    <= '0;
      out_idx   <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (in_sof) begin
        active   <= 1'b1;
        odd      <= 1'b1;
        hold     <= in_byte;
        idx      <= '0;
        last_idx <= len_last;
      end else if (active) begin
        if (!odd) begin
          hold <= in_byte;
          odd  <= 1'b1;
          if (idx == '0) last_idx <= len_last;
        end else begin
          out_valid <= 1'b1;
          out_hi    <= hold;
          out_lo    <= in_byte;
          out_idx   <= idx;
          out_first <= (idx == '0);
          out_last  <= (idx == last_idx);
          odd       <= 1'b0;
          idx       <= (idx == last_idx) ? '0 : idx + 1'b1;
        end
      end
    end
  end

endmodule

module lane_pair_splitter_chk #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_sof,
  input logic [W-1:0]  in_byte,
  input logic [1:0]    len_mode,
  input logic          out_valid,
  input logic [W-1:0]  out_hi,
  input logic [W-1:0]  out_lo,
  input logic [IW-1:0] out_idx,
  input logic          out_first,
  input logic          out_last
);

  logic seen_sof;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_sof <= 1'b0;
    else if (in_sof) seen_sof <= 1'b1;
  end

  assert_idle_before_sof_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_sof |-> !out_valid);

  assert_lo_is_odd_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lo == $past(in_byte));

  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_wrap_to_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> ##1 (!out_valid || out_first));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> ##1
      (!(out_valid && !out_first) || out_idx == IW'($past(out_idx, 2) + 1'b1)));

  assert_last_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_idx >= IW'(7) && out_idx <= IW'(9)));

  assert_sof_drops_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sof |=> !out_valid);

endmodule

bind lane_pair_splitter lane_pair_splitter_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/test_lane_pair_splitter.sv
module test_lane_pair_splitter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] len_mode = '0;
  logic       out_valid, out_first, out_last;
  logic [7:0] out_hi, out_lo;
  logic [3:0] out_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       exp_v = 1'b0;
  logic [7:0] exp_hi, exp_lo;
  logic [3:0] exp_idx;
  logic       exp_f, exp_l;
  string      vtag = "R1";
  string      ltag = "R6";

  always #2 clk = ~clk;

  lane_pair_splitter i_lane_pair_splitter (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_byte(in_byte), .len_mode(len_mode),
    .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo), .out_idx(out_idx),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] code(int u, int p, int i);
    return {u[2:0], p[0], i[3:0]};
  endfunction

  function automatic int len_of(int m);
    return (m == 1) ? 9 : (m == 2) ? 10 : 8;
  endfunction

  task automatic step(bit sof, logic [7:0] b, int mode,
                      bit nv, logic [7:0] nh, logic [7:0] nl, int ni, bit nf, bit nlst);
    @(negedge clk);
    chk(vtag, out_valid, exp_v);
    if (exp_v) begin
      chk("R2 hi", out_hi, exp_hi);
      chk("R2 lo", out_lo, exp_lo);
      chk("R4 idx", out_idx, exp_idx);
      chk("R6 first", out_first, exp_f);
      chk(ltag, out_last, exp_l);
    end
    in_sof = sof; in_byte = b; len_mode = mode[1:0];
    exp_v = nv; exp_hi = nh; exp_lo = nl; exp_idx = ni[3:0]; exp_f = nf; exp_l = nlst;
  endtask

  // Drives the first n bytes of unit u (the whole unit when n < 0); noise toggles len_mode off byte 0 (R7)
  task automatic send(int m, int u, bit sof, bit noise, int n);
    int L = len_of(m);
    int total = (n < 0) ? 2 * L : n;
    for (int k = 0; k < total; k++) begin
      int i = k / 2;
      int p = k % 2;
      int md = (k == 0) ? m : (noise ? (m + 1 + k) % 4 : m);
      step(sof && k == 0, code(u, p, i), md, p == 1, code(u, 0, i), code(u, 1, i),
           i, i == 0, i == L - 1);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int u = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", out_valid, 0);
    // R1: bytes with no start pulse are ignored
    for (int k = 0; k < 20; k++) step(0, 8'(k * 7 + 3), k % 4, 0, 0, 0, 0, 0, 0);
    vtag = "R3";
    // R5 and R4: each length mode, back to back, wrapping with no gap
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 3; r++) begin
        send(m, u, (m == 0 && r == 0), 0, -1);
        u++;
      end
    // R7: len_mode toggles everywhere except byte 0
    ltag = "R7 last";
    for (int m = 0; m < 4; m++) begin
      send(m, u, 0, 1, -1);
      u++;
    end
    ltag = "R6 last";
    // R8: restart on an odd slot after a short and a nearly full partial unit
    vtag = "R8";
    send(1, u, 0, 0, 3);
    u++;
    send(2, u, 1, 0, -1);
    u++;
    send(2, u, 0, 0, 19);
    u++;
    send(0, u, 1, 0, -1);
    u++;
    vtag = "R3";
    send(1, u, 0, 0, -1);
    u++;
    step(1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule